// File: doc/BRIEF.md
# Reservation Monitor for Linked Load and Conditional Store

This block fronts a small shared word memory that several cores reach through their own request ports. Besides plain loads and stores it offers a linked load, which returns a word and leaves a reservation on that word for the issuing core. It also offers a conditional store, which writes only while that reservation is unbroken. A conditional store reports success (1) or failure (0) in a flag, so software can build atomic read-modify-write loops and spin locks from the pair.

Each core owns one reservation: a valid bit and a word address. The block watches every write that reaches the memory. A write to a reserved word breaks the reservation of every core that holds one on that word. Requests from different cores that arrive in the same cycle are granted one at a time by fixed priority, with the lowest core index first. As a result, the memory takes at most one write per cycle, and of two racing conditional stores only one can succeed.

Each request port is valid/ready. A core holds `req_valid` and its op, address and data steady until it sees `req_ready` high at a clock edge. `req_ready` is asserted for at most one core per cycle, and that core is the lowest-indexed one with a valid request. The response side has no back-pressure. `rsp_valid` pulses for exactly one cycle, one clock after acceptance, and the core must take it then.

Top module: `llsc_monitor`

## Requirements
- R1: While reset is held and after it is released, no `rsp_valid` is high, no reservation is held, and every memory word reads 0.
- R2: In every cycle, `req_ready` is high only for the lowest-indexed core whose `req_valid` is high. At most one request is accepted per cycle, and a core that is not granted keeps waiting.
- R3: A request accepted at a clock edge gives exactly one `rsp_valid` pulse on that core in the following cycle. That response's `rsp_rdata` carries the addressed word as it was before the access.
- R4: Op encoding is 2'b00 load, 2'b01 store, 2'b10 linked load and 2'b11 conditional store. A load or linked load leaves memory unchanged. A store writes `req_wdata` and gives `rsp_ok` 0.
- R5: A conditional store whose core holds a valid reservation on the same address writes `req_wdata` and returns `rsp_ok` = 1.
- R6: A conditional store with no valid reservation, or with a reservation on a different address, returns `rsp_ok` = 0 and leaves memory unchanged.
- R7: Any memory write (a store, or a successful conditional store) to a word breaks, at that edge, every reservation held on that word, including reservations held by other cores.
- R8: A conditional store always clears its own core's reservation, whether it succeeds or fails, so a second conditional store without a new linked load fails.
- R9: A linked load replaces the core's earlier reservation, so a conditional store to the old address fails.
- R10: When two cores hold reservations on one word and both issue conditional stores to it, only the higher-priority core succeeds, and the other receives 0 with memory keeping the winner's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-core request valid |
| req_ready | output | NUM_CORES | Per-core request accepted this edge |
| req_op | input | 2*NUM_CORES | Per-core op code, 2 bits per core |
| req_addr | input | ADDR_W*NUM_CORES | Per-core word address |
| req_wdata | input | DATA_W*NUM_CORES | Per-core store data |
| rsp_valid | output | NUM_CORES | Per-core one-cycle response strobe |
| rsp_rdata | output | DATA_W*NUM_CORES | Per-core word read before the access |
| rsp_ok | output | NUM_CORES | Per-core conditional store success flag |

## Verification
The bench focuses on the corner cases where a reservation should already have been lost. These are a conditional store with no linked load, a second conditional store after the first, a linked load re-aimed at another word, a plain store by another core, and two cores racing on one word. A design that kept a reservation too long would report success in these cases and overwrite memory that the bench later reads back. A design that mis-serialized would grant two cores at once or let the lower-priority racer win. Random mixed traffic over only four addresses makes these collisions frequent, and a bench model checks every response.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LINK  = 2'b10,
    OP_COND  = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] req,
  output logic [NUM_CORES-1:0] grant,
  output logic [IDX_W-1:0]     grant_idx,
  output logic                 grant_any
);
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    grant_any = 1'b0;
    if (rst_n) begin
      for (int i = 0; i < NUM_CORES; i++) begin
        if (req[i] && !grant_any) begin
          grant[i]  = 1'b1;
          grant_idx = IDX_W'(i);
          grant_any = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_set,
  input  logic [ADDR_W-1:0] link_addr,
  input  logic              own_cond,
  input  logic              snoop_we,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              held,
  output logic [ADDR_W-1:0] held_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_addr <= '0;
    end else if (link_set) begin
      held      <= 1'b1;
      held_addr <= link_addr;
    end else if (own_cond) begin
      held      <= 1'b0;
    end else if (snoop_we && snoop_addr == held_addr) begin
      held      <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[waddr] <= wdata;
    end
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CORES-1:0]        req_valid,
  output logic [NUM_CORES-1:0]        req_ready,
  input  logic [2*NUM_CORES-1:0]      req_op,
  input  logic [ADDR_W*NUM_CORES-1:0] req_addr,
  input  logic [DATA_W*NUM_CORES-1:0] req_wdata,
  output logic [NUM_CORES-1:0]        rsp_valid,
  output logic [DATA_W*NUM_CORES-1:0] rsp_rdata,
  output logic [NUM_CORES-1:0]        rsp_ok
);
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [NUM_CORES-1:0]        grant;
  logic [IDX_W-1:0]            gidx;
  logic                        gany;
  llsc_op_e                    sel_op;
  logic [ADDR_W-1:0]           sel_addr;
  logic [DATA_W-1:0]           sel_wdata;
  logic [DATA_W-1:0]           mem_rdata;
  logic                        cond_ok;
  logic                        mem_we;
  logic [NUM_CORES-1:0]        resv_valid;
  logic [ADDR_W*NUM_CORES-1:0] resv_addr;

  llsc_arbiter #(.NUM_CORES(NUM_CORES)) u_arb (
    .rst_n(rst_n), .req(req_valid), .grant(grant),
    .grant_idx(gidx), .grant_any(gany)
  );

  assign req_ready = grant;

  always_comb begin
    sel_op    = llsc_op_e'(req_op[gidx*2 +: 2]);
    sel_addr  = req_addr[gidx*ADDR_W +: ADDR_W];
    sel_wdata = req_wdata[gidx*DATA_W +: DATA_W];
  end

  assign cond_ok = gany && (sel_op == OP_COND) && resv_valid[gidx]
                   && (resv_addr[gidx*ADDR_W +: ADDR_W] == sel_addr);
  assign mem_we  = gany && ((sel_op == OP_STORE) || cond_ok);

  llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(sel_addr),
    .wdata(sel_wdata), .raddr(sel_addr), .rdata(mem_rdata)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    llsc_resv #(.ADDR_W(ADDR_W)) u_resv (
      .clk(clk), .rst_n(rst_n),
      .link_set(grant[c] && sel_op == OP_LINK),
      .link_addr(sel_addr),
      .own_cond(grant[c] && sel_op == OP_COND),
      .snoop_we(mem_we), .snoop_addr(sel_addr),
      .held(resv_valid[c]),
      .held_addr(resv_addr[c*ADDR_W +: ADDR_W])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[c]                  <= 1'b0;
        rsp_ok[c]                     <= 1'b0;
        rsp_rdata[c*DATA_W +: DATA_W] <= '0;
      end else begin
        rsp_valid[c] <= grant[c];
        rsp_ok[c]    <= grant[c] && cond_ok;
        if (grant[c]) rsp_rdata[c*DATA_W +: DATA_W] <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_CORES-1:0]        req_valid,
  input logic [NUM_CORES-1:0]        req_ready,
  input logic [2*NUM_CORES-1:0]      req_op,
  input logic [NUM_CORES-1:0]        rsp_valid,
  input logic [NUM_CORES-1:0]        rsp_ok,
  input logic                        mem_we,
  input logic [ADDR_W-1:0]           mem_waddr,
  input logic [NUM_CORES-1:0]        resv_valid,
  input logic [ADDR_W*NUM_CORES-1:0] resv_addr
);
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_core0_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_ready[0]);

  p_rsp_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid & req_ready) != '0 |=> rsp_valid == $past(req_valid & req_ready));

  p_ok_in_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok & ~rsp_valid) == '0);

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_k
    p_write_breaks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && resv_valid[k] && mem_waddr == resv_addr[k*ADDR_W +: ADDR_W]
       && !(req_ready[k] && req_op[2*k +: 2] == 2'b10))
      |=> !resv_valid[k]);

    p_cond_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[k] && req_ready[k] && req_op[2*k +: 2] == 2'b11)
      |=> !resv_valid[k]);
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
  .mem_we(mem_we), .mem_waddr(sel_addr), .resv_valid(resv_valid),
  .resv_addr(resv_addr)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int NC = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_ready;
  logic [2*NC-1:0]  req_op = '0;
  logic [AW*NC-1:0] req_addr = '0;
  logic [DW*NC-1:0] req_wdata = '0;
  logic [NC-1:0]    rsp_valid;
  logic [DW*NC-1:0] rsp_rdata;
  logic [NC-1:0]    rsp_ok;

  always #5 clk = ~clk;

  llsc_monitor #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) u_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok)
  );

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  logic [DW-1:0] m_mem [DEPTH];
  logic          m_rv  [NC];
  logic [AW-1:0] m_ra  [NC];

  function automatic logic [NC-1:0] exp_grant(logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return NC'(1) << i;
    return '0;
  endfunction

  function automatic int grant_index(logic [NC-1:0] g);
    for (int i = 0; i < NC; i++) if (g[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive at a negedge, check ready, advance model, check response at next negedge
  task automatic step(logic [NC-1:0] v, logic [2*NC-1:0] op, logic [AW*NC-1:0] ad,
                      logic [DW*NC-1:0] wd, string tag);
    logic [NC-1:0] g;
    int gi;
    logic [1:0] o;
    logic [AW-1:0] a;
    logic [DW-1:0] old;
    logic ok;
    req_valid = v; req_op = op; req_addr = ad; req_wdata = wd;
    #1;
    g = exp_grant(v);
    chk(req_ready == g, "R2", "req_ready", DW'(req_ready), DW'(g));
    gi = grant_index(g);
    ok = 1'b0; old = '0;
    if (gi >= 0) begin
      o = op[2*gi +: 2];
      a = ad[AW*gi +: AW];
      old = m_mem[a];
      ok = (o == 2'b11) && m_rv[gi] && m_ra[gi] == a;
      if (o == 2'b10) begin m_rv[gi] = 1'b1; m_ra[gi] = a; end
      if (o == 2'b11) m_rv[gi] = 1'b0;
      if (o == 2'b01 || ok) begin
        m_mem[a] = wd[DW*gi +: DW];
        for (int k = 0; k < NC; k++) if (m_rv[k] && m_ra[k] == a) m_rv[k] = 1'b0;
      end
    end
    @(negedge clk);
    chk(rsp_valid == g, "R3", "rsp_valid", DW'(rsp_valid), DW'(g));
    if (gi >= 0) begin
      chk(rsp_rdata[DW*gi +: DW] == old, tag, "rsp_rdata", rsp_rdata[DW*gi +: DW], old);
      chk(rsp_ok[gi] == ok, tag, "rsp_ok", DW'(rsp_ok[gi]), DW'(ok));
    end
  endtask

  task automatic one(int c, logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    logic [NC-1:0] v = '0;
    logic [2*NC-1:0] op = '0;
    logic [AW*NC-1:0] ad = '0;
    logic [DW*NC-1:0] wd = '0;
    v[c] = 1'b1; op[2*c +: 2] = o; ad[AW*c +: AW] = a; wd[DW*c +: DW] = d;
    step(v, op, ad, wd, tag);
  endtask

  task automatic expect_ok(int c, bit e, string tag);
    chk(rsp_ok[c] == e, tag, "directed ok", DW'(rsp_ok[c]), DW'(e));
  endtask

  initial begin
    logic [NC-1:0] v;
    logic [2*NC-1:0] op;
    logic [AW*NC-1:0] ad;
    logic [DW*NC-1:0] wd;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    for (int k = 0; k < NC; k++) begin m_rv[k] = 1'b0; m_ra[k] = '0; end
    repeat (3) @(negedge clk);
    chk(rsp_valid == '0, "R1", "rsp_valid in reset", DW'(rsp_valid), 0);
    chk(req_ready == '0, "R1", "req_ready in reset", DW'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == '0, "R1", "rsp_valid after reset", DW'(rsp_valid), 0);
    for (int i = 0; i < 4; i++) one(i % NC, 2'b00, AW'(i), '0, "R1");
    one(0, 2'b11, 4'd1, 32'hDEAD, "R6");  expect_ok(0, 1'b0, "R6");
    one(0, 2'b00, 4'd1, '0, "R6");
    one(1, 2'b10, 4'd2, '0, "R4");
    one(1, 2'b11, 4'd2, 32'h1111, "R5");  expect_ok(1, 1'b1, "R5");
    one(1, 2'b11, 4'd2, 32'h2222, "R8");  expect_ok(1, 1'b0, "R8");
    one(2, 2'b10, 4'd3, '0, "R4");
    one(0, 2'b01, 4'd3, 32'h3333, "R4");
    one(2, 2'b11, 4'd3, 32'h4444, "R7");  expect_ok(2, 1'b0, "R7");
    one(3, 2'b10, 4'd4, '0, "R9");
    one(3, 2'b10, 4'd5, '0, "R9");
    one(3, 2'b11, 4'd4, 32'h5555, "R9");  expect_ok(3, 1'b0, "R9");
    one(3, 2'b10, 4'd6, '0, "R6");
    one(3, 2'b11, 4'd7, 32'h5656, "R6");  expect_ok(3, 1'b0, "R6");
    one(1, 2'b10, 4'd6, '0, "R10");
    one(2, 2'b10, 4'd6, '0, "R10");
    v = 4'b0110; op = '0; ad = '0; wd = '0;
    op[3:2] = 2'b11; op[5:4] = 2'b11; ad[7:4] = 4'd6; ad[11:8] = 4'd6;
    wd[63:32] = 32'hAAAA; wd[95:64] = 32'hBBBB;
    step(v, op, ad, wd, "R10");           expect_ok(1, 1'b1, "R10");
    one(2, 2'b11, 4'd6, 32'hBBBB, "R10"); expect_ok(2, 1'b0, "R10");
    one(0, 2'b00, 4'd6, '0, "R10");
    chk(rsp_rdata[DW-1:0] == 32'hAAAA, "R10", "winner value", rsp_rdata[DW-1:0], 32'hAAAA);
    for (int n = 0; n < 400; n++) begin
      v = NC'($urandom);
      for (int c = 0; c < NC; c++) begin
        op[2*c +: 2] = 2'($urandom);
        ad[AW*c +: AW] = AW'($urandom % 4);
        wd[DW*c +: DW] = $urandom;
      end
      step(v, op, ad, wd, "R7");
    end
    req_valid = '0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end
endmodule